// File: doc/BRIEF.md
# Interrupt Entry Front End

This block sits beside an instruction sequencer and decides, at each instruction boundary, whether an interrupt is taken and which vector goes with it. Two request lines feed it. The maskable line is a level request that counts only while the interrupt enable flag is set. The non-maskable line is an edge request that is filtered for a clean low-then-high shape and then remembered until it is serviced.

When the maskable request wins a boundary, the block asks the bus unit for two back-to-back interrupt-acknowledge cycles and holds the bus lock for the whole pair. The byte returned by the second cycle becomes the vector, and the first cycle's byte is dropped. When the non-maskable request wins, no bus traffic is generated and the fixed internal vector 2 is presented on the cycle after the boundary. Both request pins may be asynchronous, so each passes through a synchronizer before any decision is made.

Top module: `irq_front`

## Requirements
- R1: While reset is asserted and on the first cycle after it, ack_req_o, lock_o and vec_valid_o are 0 and vec_o is 8'h00.
- R2: With ien_i = 1 and intr_i held high long enough (R4), an insn_end_i pulse on an idle block raises ack_req_o and lock_o on the next cycle.
- R3: With ien_i = 0, a boundary with intr_i high and no pending non-maskable request produces no ack_req_o and no vec_valid_o.
- R4: intr_i is only taken if its synchronized level has been high on at least two clock edges before the boundary; raising intr_i in the boundary cycle itself is not taken.
- R5: An acknowledge sequence is two bus cycles, each ended by one bus_done_i pulse; ack_req_o stays high through both, the byte on the first completion is discarded, and the byte on the second completion appears on vec_o with a one-cycle vec_valid_o pulse on the next cycle, while ack_req_o falls at that same edge.
- R6: lock_o is high on every cycle that ack_req_o is high and falls together with it after the second completion.
- R7: A serviced non-maskable request gives vec_valid_o = 1 with vec_o = 8'h02 on the cycle after the boundary, with no acknowledge cycle, whatever ien_i is.
- R8: nmi_i is recognized only after its synchronized level is low for at least 4 clocks and then high for at least 4 clocks; a 3-clock high pulse, or a line that is high from reset, is not recognized.
- R9: A recognized non-maskable request stays pending across any number of cycles, including a whole acknowledge sequence, and is serviced at the next boundary of an idle block.
- R10: When a non-maskable request is pending at a boundary where the maskable request also qualifies, the non-maskable one is serviced and no acknowledge cycle starts.
- R11: insn_end_i pulses while an acknowledge sequence is in progress are ignored: no vector is produced and the pending request is not consumed.
- R12: Without an insn_end_i pulse nothing is serviced: vec_valid_o stays 0 and vec_o does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| intr_i | input | 1 | Maskable level request, active high, asynchronous |
| nmi_i | input | 1 | Non-maskable request, active high, asynchronous |
| ien_i | input | 1 | Interrupt enable flag |
| insn_end_i | input | 1 | One-cycle instruction-boundary strobe |
| bus_d_i | input | 8 | Data bus byte during acknowledge cycles |
| bus_done_i | input | 1 | One-cycle strobe ending the current acknowledge bus cycle |
| ack_req_o | output | 1 | Request for an interrupt-acknowledge bus cycle |
| lock_o | output | 1 | Bus lock request |
| vec_valid_o | output | 1 | One-cycle pulse: vec_o holds a new vector |
| vec_o | output | 8 | Interrupt vector |

## Verification
The boundary decision is tried with the maskable line alone with the enable flag set and clear, the non-maskable line alone with the flag set and clear, both lines together, and neither line, which separates masking from priority and from idle boundaries. Acknowledge data uses distinct first and second bytes, including all-ones then all-zeros, so that keeping the wrong byte is visible. Directed cases shape the non-maskable line as a short pulse and as a level held from reset, raise the maskable line in the boundary cycle, and land a non-maskable edge plus a stray boundary inside an acknowledge sequence to show it is held, not lost and not taken early.

// File: rtl/irq_pkg.sv
package irq_pkg;

  typedef enum logic [1:0] {
    SEQ_IDLE = 2'd0,
    SEQ_ACK1 = 2'd1,
    SEQ_ACK2 = 2'd2
  } seq_e;

  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_NMI  = 2'd1,
    SRC_INTR = 2'd2
  } src_e;

  // Saturating increment used by every qualifier counter.
  function automatic int unsigned sat_next(input int unsigned cur, input int unsigned lim);
    return (cur >= lim) ? lim : cur + 1;
  endfunction

  // Boundary arbitration: the edge request beats the level request.
  function automatic src_e pick_src(input logic boundary, input logic idle,
                                    input logic nmi_pend, input logic ien,
                                    input logic intr_ready);
    if (!(boundary && idle)) return SRC_NONE;
    if (nmi_pend)            return SRC_NMI;
    if (ien && intr_ready)   return SRC_INTR;
    return SRC_NONE;
  endfunction

endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
  parameter int WIDTH  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] stg [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[s] <= '0;
          else        stg[s] <= stg[s-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/nmi_qual.sv
module nmi_qual
  import irq_pkg::*;
#(
  parameter int LOW_CLKS  = 4,
  parameter int HIGH_CLKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic fire_o
);
  localparam int LW = $clog2(LOW_CLKS + 1);
  localparam int HW = $clog2(HIGH_CLKS + 1);

  logic [LW-1:0] lo_cnt;
  logic [HW-1:0] hi_cnt;
  logic          armed;
  logic          arm_now;

  assign arm_now = !lvl && (lo_cnt >= LW'(LOW_CLKS - 1));
  assign fire_o  = lvl && armed && (hi_cnt == HW'(HIGH_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lo_cnt <= '0;
      hi_cnt <= '0;
      armed  <= 1'b0;
    end else if (!lvl) begin
      hi_cnt <= '0;
      lo_cnt <= LW'(sat_next(int'(lo_cnt), LOW_CLKS));
      if (arm_now) armed <= 1'b1;
    end else begin
      lo_cnt <= '0;
      hi_cnt <= HW'(sat_next(int'(hi_cnt), HIGH_CLKS));
      if (fire_o) armed <= 1'b0;
    end
  end
endmodule

// File: rtl/intr_qual.sv
module intr_qual
  import irq_pkg::*;
#(
  parameter int LEAD = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic lvl,
  output logic ready_o
);
  localparam int CW = $clog2(LEAD + 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   cnt <= '0;
    else if (lvl) cnt <= CW'(sat_next(int'(cnt), LEAD));
    else          cnt <= '0;
  end

  assign ready_o = lvl && (cnt == CW'(LEAD));
endmodule

// File: rtl/ack_seq.sv
module ack_seq
  import irq_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic bus_done,
  output logic idle_o,
  output logic ack_req_o,
  output logic lock_o,
  output logic grab_o
);
  seq_e state, state_nx;
  logic lock_q;

  always_comb begin
    state_nx = state;
    unique case (state)
      SEQ_IDLE: if (start)    state_nx = SEQ_ACK1;
      SEQ_ACK1: if (bus_done) state_nx = SEQ_ACK2;
      SEQ_ACK2: if (bus_done) state_nx = SEQ_IDLE;
      default:                state_nx = SEQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state  <= SEQ_IDLE;
      lock_q <= 1'b0;
    end else begin
      state <= state_nx;
      if (start && state == SEQ_IDLE) lock_q <= 1'b1;
      else if (grab_o)                lock_q <= 1'b0;
    end
  end

  assign idle_o    = (state == SEQ_IDLE);
  assign ack_req_o = (state != SEQ_IDLE);
  assign lock_o    = lock_q;
  assign grab_o    = (state == SEQ_ACK2) && bus_done;
endmodule

// File: rtl/irq_front.sv
module irq_front
  import irq_pkg::*;
#(
  parameter int          VEC_W     = 8,
  parameter int          SYNC_STG  = 2,
  parameter int          INTR_LEAD = 2,
  parameter int          NMI_LOW   = 4,
  parameter int          NMI_HIGH  = 4,
  parameter logic [7:0]  NMI_VEC   = 8'h02
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             intr_i,
  input  logic             nmi_i,
  input  logic             ien_i,
  input  logic             insn_end_i,
  input  logic [VEC_W-1:0] bus_d_i,
  input  logic             bus_done_i,
  output logic             ack_req_o,
  output logic             lock_o,
  output logic             vec_valid_o,
  output logic [VEC_W-1:0] vec_o
);
  // Named internal events, also observed by the bound checker.
  logic [1:0] req_s;
  logic       intr_s, nmi_s;
  logic       intr_ready;
  logic       nmi_fire;
  logic       nmi_pend;
  logic       seq_idle;
  logic       grab;
  logic       take_nmi, take_intr;
  src_e       src;

  logic [VEC_W-1:0] vec_q;
  logic             vec_valid_q;

  irq_sync #(.WIDTH(2), .STAGES(SYNC_STG)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({nmi_i, intr_i}), .q(req_s)
  );
  assign intr_s = req_s[0];
  assign nmi_s  = req_s[1];

  intr_qual #(.LEAD(INTR_LEAD)) u_intr (
    .clk(clk), .rst_n(rst_n), .lvl(intr_s), .ready_o(intr_ready)
  );

  nmi_qual #(.LOW_CLKS(NMI_LOW), .HIGH_CLKS(NMI_HIGH)) u_nmi (
    .clk(clk), .rst_n(rst_n), .lvl(nmi_s), .fire_o(nmi_fire)
  );

  assign src       = pick_src(insn_end_i, seq_idle, nmi_pend, ien_i, intr_ready);
  assign take_nmi  = (src == SRC_NMI);
  assign take_intr = (src == SRC_INTR);

  ack_seq u_seq (
    .clk(clk), .rst_n(rst_n), .start(take_intr), .bus_done(bus_done_i),
    .idle_o(seq_idle), .ack_req_o(ack_req_o), .lock_o(lock_o), .grab_o(grab)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_pend    <= 1'b0;
      vec_q       <= '0;
      vec_valid_q <= 1'b0;
    end else begin
      nmi_pend    <= (nmi_pend && !take_nmi) || nmi_fire;
      vec_valid_q <= take_nmi || grab;
      if (take_nmi)  vec_q <= VEC_W'(NMI_VEC);
      else if (grab) vec_q <= bus_d_i;
    end
  end

  assign vec_o       = vec_q;
  assign vec_valid_o = vec_valid_q;
endmodule

// File: rtl/irq_front_chk.sv
module irq_front_chk #(
  parameter int         VEC_W   = 8,
  parameter logic [7:0] NMI_VEC = 8'h02
) (
  input logic             clk,
  input logic             rst_n,
  input logic             ien_i,
  input logic             insn_end_i,
  input logic             ack_req_o,
  input logic             lock_o,
  input logic             vec_valid_o,
  input logic [VEC_W-1:0] vec_o,
  input logic             take_nmi,
  input logic             take_intr,
  input logic             nmi_fire,
  input logic             nmi_pend,
  input logic             seq_idle,
  input logic             nmi_s,
  input logic             grab
);
  AST_INTR_STARTS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr |=> (ack_req_o && lock_o)); // R2

  AST_MASKED_NO_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    (insn_end_i && seq_idle && !ien_i && !nmi_pend) |=> !ack_req_o); // R3

  AST_VALID_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    vec_valid_o |-> ($past(take_nmi) || $past(grab))); // R5

  AST_LOCK_COVERS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
    ack_req_o |-> lock_o); // R6

  AST_NMI_FIXED_VEC: assert property (@(posedge clk) disable iff (!rst_n)
    take_nmi |=> (vec_valid_o && vec_o == VEC_W'(NMI_VEC) && !ack_req_o)); // R7

  AST_NMI_FIRE_AFTER_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_fire |-> $past(nmi_s)); // R8

  AST_NMI_PEND_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_pend && !take_nmi) |=> nmi_pend); // R9

  AST_NMI_BEATS_INTR: assert property (@(posedge clk) disable iff (!rst_n)
    take_intr |-> !nmi_pend); // R10

  AST_BUSY_NO_TAKE: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle |-> (!take_nmi && !take_intr)); // R11

  AST_VEC_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_valid_o |-> $stable(vec_o)); // R12

  AST_ONE_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({take_nmi, take_intr, grab})); // R5
endmodule

bind irq_front irq_front_chk #(.VEC_W(VEC_W), .NMI_VEC(NMI_VEC)) u_chk (
  .clk(clk), .rst_n(rst_n), .ien_i(ien_i), .insn_end_i(insn_end_i),
  .ack_req_o(ack_req_o), .lock_o(lock_o), .vec_valid_o(vec_valid_o),
  .vec_o(vec_o), .take_nmi(take_nmi), .take_intr(take_intr),
  .nmi_fire(nmi_fire), .nmi_pend(nmi_pend), .seq_idle(seq_idle),
  .nmi_s(nmi_s), .grab(grab)
);

// File: tb/irq_front_test.sv
module irq_front_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       intr_i = 1'b0, nmi_i = 1'b0, ien_i = 1'b0, insn_end_i = 1'b0;
  logic [7:0] bus_d_i = 8'h00;
  logic       bus_done_i = 1'b0;
  logic       ack_req_o, lock_o, vec_valid_o;
  logic [7:0] vec_o;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  irq_front uut (
    .clk(clk), .rst_n(rst_n), .intr_i(intr_i), .nmi_i(nmi_i), .ien_i(ien_i),
    .insn_end_i(insn_end_i), .bus_d_i(bus_d_i), .bus_done_i(bus_done_i),
    .ack_req_o(ack_req_o), .lock_o(lock_o), .vec_valid_o(vec_valid_o), .vec_o(vec_o)
  );

  localparam logic [7:0] NMI_VECTOR = 8'h02;
  localparam logic [1:0] K_NONE = 2'd0, K_NMI = 2'd1, K_INTR = 2'd2;

  typedef struct packed {
    logic       nmi;
    logic       intr;
    logic       ien;
    logic [7:0] b1;
    logic [7:0] b2;
    logic [1:0] kind;
  } step_t;

  localparam int NSTEP = 8;
  localparam step_t TBL [NSTEP] = '{
    '{1'b0, 1'b1, 1'b1, 8'h11, 8'h48, K_INTR},  // R2 R5
    '{1'b0, 1'b1, 1'b0, 8'h22, 8'h33, K_NONE},  // R3
    '{1'b1, 1'b0, 1'b0, 8'h00, 8'h00, K_NMI },  // R7 flag clear
    '{1'b1, 1'b1, 1'b1, 8'h44, 8'h55, K_NMI },  // R10
    '{1'b0, 1'b1, 1'b1, 8'hFF, 8'h00, K_INTR},  // R5 all-ones then zero
    '{1'b0, 1'b0, 1'b1, 8'h00, 8'h00, K_NONE},  // R12
    '{1'b1, 1'b0, 1'b1, 8'h00, 8'h00, K_NMI },  // R7 flag set
    '{1'b0, 1'b1, 1'b1, 8'h00, 8'hA5, K_INTR}   // R5
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected next state of the front end, restated from the requirements.
  function automatic logic [1:0] expect_kind(input logic nmi_pending, input logic ien,
                                             input logic intr_long);
    if (nmi_pending)      return K_NMI;
    if (ien && intr_long) return K_INTR;
    return K_NONE;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic boundary();
    insn_end_i = 1'b1;
    cyc(1);
    insn_end_i = 1'b0;
  endtask

  task automatic nmi_pulse(input int hi);
    nmi_i = 1'b1;
    cyc(hi);
    nmi_i = 1'b0;
    cyc(8);
  endtask

  // Two acknowledge bus cycles; called on the cycle after the boundary.
  task automatic serve_ack(input logic [7:0] b1, input logic [7:0] b2, input int gap);
    bit lock_ok = 1'b1;
    for (int i = 0; i < gap; i++) begin
      if (!(ack_req_o && lock_o)) lock_ok = 1'b0;
      cyc(1);
    end
    bus_d_i = b1; bus_done_i = 1'b1;
    cyc(1);
    bus_done_i = 1'b0; bus_d_i = 8'h5A;
    chk(ack_req_o === 1'b1 && vec_valid_o === 1'b0, "R5 second cycle pending",
        {ack_req_o, vec_valid_o}, 2'b10);
    if (!(ack_req_o && lock_o)) lock_ok = 1'b0;
    cyc(2);
    bus_d_i = b2; bus_done_i = 1'b1;
    cyc(1);
    bus_done_i = 1'b0; bus_d_i = 8'h00;
    chk(vec_valid_o === 1'b1 && vec_o === b2, "R5 vector from second cycle",
        {vec_valid_o, vec_o}, {1'b1, b2});
    chk(ack_req_o === 1'b0 && lock_o === 1'b0, "R6 lock released with request",
        {ack_req_o, lock_o}, 2'b00);
    chk(lock_ok, "R6 lock held through sequence", lock_ok, 1);
    cyc(1);
    chk(vec_valid_o === 1'b0, "R5 valid is one pulse", vec_valid_o, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : main
    logic [1:0] k;
    bit quiet;
    // R1 reset state
    cyc(3);
    chk({ack_req_o, lock_o, vec_valid_o, vec_o} === 11'h0, "R1 in reset",
        {ack_req_o, lock_o, vec_valid_o, vec_o}, 0);
    rst_n = 1'b1;
    cyc(1);
    chk({ack_req_o, lock_o, vec_valid_o, vec_o} === 11'h0, "R1 after reset",
        {ack_req_o, lock_o, vec_valid_o, vec_o}, 0);
    cyc(10);

    for (int s = 0; s < NSTEP; s++) begin
      ien_i  = TBL[s].ien;
      intr_i = TBL[s].intr;
      if (TBL[s].nmi) nmi_pulse(6);
      else            cyc(14);
      k = expect_kind(TBL[s].nmi, TBL[s].ien, TBL[s].intr);
      boundary();
      intr_i = 1'b0;
      case (k)
        K_NMI: begin
          chk(vec_valid_o === 1'b1 && vec_o === NMI_VECTOR && ack_req_o === 1'b0,
              "R7 R10 fixed vector no ack", {vec_valid_o, ack_req_o, vec_o},
              {2'b10, NMI_VECTOR});
        end
        K_INTR: begin
          chk(ack_req_o === 1'b1 && lock_o === 1'b1 && vec_valid_o === 1'b0,
              "R2 ack started", {ack_req_o, lock_o, vec_valid_o}, 3'b110);
          serve_ack(TBL[s].b1, TBL[s].b2, 3);
        end
        default: begin
          chk(ack_req_o === 1'b0 && vec_valid_o === 1'b0, "R3 R12 nothing taken",
              {ack_req_o, vec_valid_o}, 0);
        end
      endcase
      cyc(4);
    end

    // R4: request raised in the boundary cycle is too late
    ien_i = 1'b1;
    intr_i = 1'b1;
    boundary();
    chk(ack_req_o === 1'b0, "R4 late request not taken", ack_req_o, 0);
    intr_i = 1'b0;
    cyc(6);

    // R8: a three-clock pulse is not recognized
    nmi_pulse(3);
    boundary();
    chk(vec_valid_o === 1'b0, "R8 short pulse ignored", vec_valid_o, 0);
    cyc(4);

    // R9 R11: edge during acknowledge is held; stray boundary ignored
    intr_i = 1'b1;
    cyc(8);
    boundary();
    intr_i = 1'b0;
    chk(ack_req_o === 1'b1, "R9 ack under way", ack_req_o, 1);
    nmi_i = 1'b1;
    cyc(6);
    nmi_i = 1'b0;
    cyc(4);
    boundary();
    chk(vec_valid_o === 1'b0 && ack_req_o === 1'b1, "R11 boundary ignored while busy",
        {vec_valid_o, ack_req_o}, 2'b01);
    serve_ack(8'h33, 8'h66, 1);
    quiet = 1'b1;
    for (int i = 0; i < 12; i++) begin
      if (vec_valid_o !== 1'b0 || vec_o !== 8'h66) quiet = 1'b0;
      cyc(1);
    end
    chk(quiet, "R12 no vector without boundary", quiet, 1);
    boundary();
    chk(vec_valid_o === 1'b1 && vec_o === NMI_VECTOR, "R9 held request serviced",
        {vec_valid_o, vec_o}, {1'b1, NMI_VECTOR});
    cyc(4);

    // R8: line high from reset is never recognized
    nmi_i = 1'b1;
    rst_n = 1'b0;
    cyc(3);
    rst_n = 1'b1;
    cyc(14);
    boundary();
    chk(vec_valid_o === 1'b0 && vec_o === 8'h00, "R8 high from reset ignored",
        {vec_valid_o, vec_o}, 0);
    nmi_i = 1'b0;
    cyc(4);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule